// File: doc/BRIEF.md
# Carry-Save Quarter-Scaled Multiply-Add Unit

The unit takes two unsigned 4-bit operands and returns one quarter of their product plus one. The result is exact and needs no rounding. All sixteen AND-gate partial-product bits and the constant go into one linear array of carry-save rows. A single carry-propagate adder turns the last sum/carry pair into the final value, and an output register holds that value.

The scaling by one quarter costs no logic. The output is read as fixed point with two fraction bits, so the raw integer leaving the adder is X·Y + 4. The constant one therefore becomes a single bit of weight 4. It sits in a bit position that the last partial-product row leaves empty, so it adds no carry-save row and no adder of its own.

A caller presents operands with a valid strobe. One clock later it reads the result with its own valid strobe. A new operand pair may be accepted on every clock.

Top module: `qm_muladd_csa`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `z_out` = 0 and `out_vld` = 0.
- R2: When `in_vld` is high at an edge, `z_out` after that edge holds X·Y + 4 as an 8-bit unsigned code. Bits [7:2] are the integer part and bits [1:0] the fraction, so the code equals 4·Z with Z = 0.25·X·Y + 1.
- R3: `out_vld` after an edge equals `in_vld` sampled at that edge, giving a latency of exactly one clock.
- R4: When `in_vld` is low at an edge, `z_out` keeps its previous value whatever `x_in` and `y_in` carry.
- R5: For X = Y = 15 the code is 8'b11100101 (57.25), and no operand pair ever gives a code above it.
- R6: If either operand is zero the code is 8'b00000100 (1.00), the smallest code a valid result can take.
- R7: Valid pairs on consecutive clocks produce valid results on consecutive clocks, in the same order, with no bubble.
- R8: When reset and `in_vld` are both asserted at the same edge, reset wins: the pair is dropped, and `z_out` = 0 and `out_vld` = 0 follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand pair is valid this cycle |
| x_in | input | 4 | Unsigned operand X |
| y_in | input | 4 | Unsigned operand Y |
| out_vld | output | 1 | `z_out` holds a fresh result |
| z_out | output | 8 | Result 4·Z, 6 integer and 2 fraction bits |

## Verification
Two events can fall in one cycle: a load of a new result, and a synchronous reset. The bench provokes this by driving `rst_n` low in the same cycle as `in_vld` high with non-zero operands. It then expects a cleared, invalid output and no result for that pair in its scoreboard. The same clear-versus-hold question is also exercised at the border between a stream of valid pairs and idle cycles with changing operands. There the held value must be the last result loaded, not the operands on the bus.

// File: rtl/qm_muladd_pkg.sv
// Package qm_muladd_pkg
// Holds the shared sizing helpers for the quarter-scaled multiply-add unit.
// Assumes operand widths of at least four bits, so that the product plus
// offset always fits in twice the operand width.
package qm_muladd_pkg;

    // Default operand width.
    localparam int unsigned QM_OP_W_DEF   = 4;
    // Fraction bits created by the power-of-two scaling.
    localparam int unsigned QM_FRAC_W_DEF = 2;

    // Width of the scaled-integer result for a given operand width.
    function automatic int unsigned qm_res_w(input int unsigned op_w);
        return 2 * op_w;
    endfunction

    // Largest scaled-integer result: full-scale product plus one unit.
    function automatic int unsigned qm_res_max(input int unsigned op_w,
                                               input int unsigned frac_w);
        return ((1 << op_w) - 1) * ((1 << op_w) - 1) + (1 << frac_w);
    endfunction

endpackage

// File: rtl/qm_pp_gen.sv
// Module qm_pp_gen
// Forms one partial-product row per bit of Y, each already placed at its
// weight in the scaled-integer domain. The offset bit (weight 2**FRAC_W)
// goes into the last row, whose low positions are otherwise empty.
// Assumes FRAC_W < OP_W-1, so the offset position is free in that row.
module qm_pp_gen #(
    parameter int unsigned OP_W   = 4,
    parameter int unsigned FRAC_W = 2,
    parameter int unsigned RES_W  = 8
) (
    input  logic [OP_W-1:0]             x_op,
    input  logic [OP_W-1:0]             y_op,
    output logic [OP_W-1:0][RES_W-1:0]  pp_rows
);

    localparam int unsigned LAST_ROW = OP_W - 1;

    for (genvar r = 0; r < OP_W; r++) begin : g_row
        for (genvar k = 0; k < RES_W; k++) begin : g_bit
            if ((k >= r) && (k < r + OP_W)) begin : g_and
                // Product bit: X bit (k-r) gated by Y bit r.
                assign pp_rows[r][k] = x_op[k - r] & y_op[r];
            end else if ((r == LAST_ROW) && (k == FRAC_W)) begin : g_ofs
                // Constant offset injected in the empty slot.
                assign pp_rows[r][k] = 1'b1;
            end else begin : g_zero
                assign pp_rows[r][k] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/qm_csa_row.sv
// Module qm_csa_row
// One carry-save row: three vectors in, a sum vector and a left-shifted
// carry vector out. The top carry is dropped; callers guarantee the full
// sum fits in W bits.
module qm_csa_row #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] cry_v
);

    logic [W-1:0] maj_v;

    for (genvar k = 0; k < W; k++) begin : g_fa
        // Per-bit full adder: parity to sum, majority to carry.
        assign sum_v[k] = in_a[k] ^ in_b[k] ^ in_c[k];
        assign maj_v[k] = (in_a[k] & in_b[k]) | (in_a[k] & in_c[k]) | (in_b[k] & in_c[k]);
    end

    // Carry weight is one place higher than its source column.
    assign cry_v[0] = 1'b0;
    for (genvar k = 1; k < W; k++) begin : g_shift
        assign cry_v[k] = maj_v[k - 1];
    end

endmodule

// File: rtl/qm_csa_array.sv
// Module qm_csa_array
// Linear carry-save array: the first two rows seed the redundant pair, and
// each later row is folded in by one qm_csa_row. N rows need N-2 levels.
// Assumes N_ROWS >= 3.
module qm_csa_array #(
    parameter int unsigned N_ROWS = 4,
    parameter int unsigned W      = 8
) (
    input  logic [N_ROWS-1:0][W-1:0] rows_in,
    output logic [W-1:0]             red_sum,
    output logic [W-1:0]             red_cry
);

    localparam int unsigned N_LVL = N_ROWS - 1;

    logic [N_LVL-1:0][W-1:0] lvl_s;
    logic [N_LVL-1:0][W-1:0] lvl_c;

    // Seed level: rows 0 and 1 already form a valid redundant pair.
    assign lvl_s[0] = rows_in[0];
    assign lvl_c[0] = rows_in[1];

    for (genvar j = 1; j < N_LVL; j++) begin : g_lvl
        qm_csa_row #(.W(W)) u_row (
            .in_a  (lvl_s[j - 1]),
            .in_b  (lvl_c[j - 1]),
            .in_c  (rows_in[j + 1]),
            .sum_v (lvl_s[j]),
            .cry_v (lvl_c[j])
        );
    end

    assign red_sum = lvl_s[N_LVL - 1];
    assign red_cry = lvl_c[N_LVL - 1];

endmodule

// File: rtl/qm_cpa.sv
// Module qm_cpa
// Ripple carry-propagate adder that resolves the redundant pair. The carry
// out of the top bit is not formed; the result is known to fit in W bits.
module qm_cpa #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] cc;

    assign cc[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_bit
        // Sum bit for column k.
        assign sum_o[k] = op_a[k] ^ op_b[k] ^ cc[k];
        if (k < W - 1) begin : g_cy
            // Carry into column k+1.
            assign cc[k + 1] = (op_a[k] & op_b[k]) | (cc[k] & (op_a[k] ^ op_b[k]));
        end
    end

endmodule

// File: rtl/qm_muladd_csa.sv
// Module qm_muladd_csa (top)
// Registered Z = X*Y/4 + 1 for unsigned operands. The output code is the
// scaled integer 4*Z with FRAC_W fraction bits. Combinational path:
// partial products -> carry-save array -> ripple CPA -> output register.
// Assumes OP_W >= 4 and FRAC_W == 2 for the one-quarter scale.
module qm_muladd_csa
    import qm_muladd_pkg::*;
#(
    parameter int unsigned OP_W   = QM_OP_W_DEF,
    parameter int unsigned FRAC_W = QM_FRAC_W_DEF,
    parameter int unsigned RES_W  = qm_res_w(OP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    output logic             out_vld,
    output logic [RES_W-1:0] z_out
);

    logic [OP_W-1:0][RES_W-1:0] pp_rows;
    logic [RES_W-1:0]           red_sum;
    logic [RES_W-1:0]           red_cry;
    logic [RES_W-1:0]           z_next;

    qm_pp_gen #(.OP_W(OP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_pp (
        .x_op    (x_in),
        .y_op    (y_in),
        .pp_rows (pp_rows)
    );

    qm_csa_array #(.N_ROWS(OP_W), .W(RES_W)) u_arr (
        .rows_in (pp_rows),
        .red_sum (red_sum),
        .red_cry (red_cry)
    );

    qm_cpa #(.W(RES_W)) u_cpa (
        .op_a  (red_sum),
        .op_b  (red_cry),
        .sum_o (z_next)
    );

    // Output register: clear on reset, load on valid, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_out   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                z_out <= z_next;
            end
        end
    end

endmodule

// File: rtl/qm_muladd_csa_chk.sv
// Module qm_muladd_csa_chk
// Port-level properties of qm_muladd_csa; attached by bind below.
module qm_muladd_csa_chk
    import qm_muladd_pkg::*;
#(
    parameter int unsigned OP_W   = QM_OP_W_DEF,
    parameter int unsigned FRAC_W = QM_FRAC_W_DEF,
    parameter int unsigned RES_W  = qm_res_w(OP_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [OP_W-1:0]  x_in,
    input logic [OP_W-1:0]  y_in,
    input logic             out_vld,
    input logic [RES_W-1:0] z_out
);

    localparam logic [RES_W-1:0] Z_MAX = RES_W'(qm_res_max(OP_W, FRAC_W));
    localparam logic [RES_W-1:0] Z_MIN = RES_W'(1 << FRAC_W);

    logic [RES_W-1:0] ref_code;
    assign ref_code = RES_W'(x_in) * RES_W'(y_in) + Z_MIN;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (z_out == '0) && !out_vld);                                      // R1
    AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> z_out == $past(ref_code));                                        // R2
    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);                                                          // R3
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);                                                        // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && $past(rst_n)) |=> $stable(z_out));                                // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> z_out <= Z_MAX);                                                   // R5
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> z_out >= Z_MIN);                                                   // R6

endmodule

bind qm_muladd_csa qm_muladd_csa_chk #(
    .OP_W(OP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in), .y_in(y_in),
    .out_vld(out_vld), .z_out(z_out)
);

// File: tb/qm_muladd_csa_test.sv
// Scoreboard bench for qm_muladd_csa: the driver queues expected codes,
// the monitor pops and compares each result as it appears.
module qm_muladd_csa_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] x_in = '0;
    logic [3:0] y_in = '0;
    logic       out_vld;
    logic [7:0] z_out;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_en = 1'b0;
    logic [7:0] last_z = '0;
    logic [7:0] exp_q[$];

    qm_muladd_csa uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in), .y_in(y_in),
        .out_vld(out_vld), .z_out(z_out)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; queue the expected code when valid.
    task automatic drive(input bit v, input int a, input int b);
        @(negedge clk);
        in_vld = v;
        x_in   = 4'(a);
        y_in   = 4'(b);
        if (v && rst_n) exp_q.push_back(8'(a * b + 4));
    endtask

    // Monitor: samples 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (mon_en) begin
                check(out_vld == (exp_q.size() > 0), "R3 out_vld", int'(out_vld),
                      int'(exp_q.size() > 0));
                if (out_vld && exp_q.size() > 0) begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    if (e == 8'b11100101)
                        check(z_out == e, "R5 full-scale code", z_out, e);
                    else if (e == 8'b00000100)
                        check(z_out == e, "R6 zero operand", z_out, e);
                    else
                        check(z_out == e, "R2/R7 result", z_out, e);
                    last_z = e;
                end else if (!out_vld) begin
                    check(z_out == last_z, "R4 hold when idle", z_out, last_z);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(z_out == 8'd0, "R1 reset z_out", z_out, 0);
        check(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R2, R7: every operand pair, back to back.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                drive(1'b1, a, b);
            end
        end

        // R4: idle cycles with moving operands between sparse valid pairs.
        for (int i = 0; i < 12; i++) begin
            drive(1'b0, (i * 5) % 16, (i * 11) % 16);
            drive(1'b0, 15, 15);
            if (i % 3 == 0) drive(1'b1, i, 15 - i);
        end
        drive(1'b1, 15, 15);
        drive(1'b1, 0, 9);
        drive(1'b1, 13, 0);
        repeat (3) drive(1'b0, 7, 7);

        // R8: reset and valid in the same cycle; reset wins.
        @(negedge clk);
        mon_en = 1'b0;
        rst_n  = 1'b0;
        in_vld = 1'b1;
        x_in   = 4'd7;
        y_in   = 4'd9;
        @(posedge clk);
        #5;
        check(z_out == 8'd0, "R8 reset beats load z_out", z_out, 0);
        check(out_vld == 1'b0, "R8 reset beats load out_vld", out_vld, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        in_vld = 1'b0;
        last_z = '0;
        exp_q.delete();
        mon_en = 1'b1;

        // Recovery after reset.
        drive(1'b1, 6, 10);
        drive(1'b1, 3, 3);
        repeat (3) drive(1'b0, 1, 2);

        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule